// File: doc/BRIEF.md
# UART Interrupt Status and Control Register Block

This block holds the interrupt status word and the control word of a high-speed serial port. The FIFOs and the serial engine sit outside it. They report to it through event pulses (framing error, break seen, receive overrun), through receive-side level flags (trigger reached, idle timeout) and through the current transmit and receive FIFO occupancy. Software reaches the block through a 32-bit memory-mapped port with a byte address, a write strobe and a combinational read data path.

Error events and the transmit request latch into status bits. Software clears them by writing ones to the status word. The two receive bits are not latched: they follow their inputs. Three enable bits in the control word gate the status bits, one class each for transmit, receive and error, and the gated bits are combined into a single interrupt line. The control word also drives these outputs:
- the break-transmit output
- the transmit and receive trigger selects
- the receiver sampling offset

A rate word feeds the baud divider.

Top module: `uart_irq_ctrl_regs`

## Requirements
- R1: After reset, status and control read 0, the rate word reads 0xFF, and irq_o and brk_o are 0.
- R2: Control at byte address 0x0C stores bits 13:0 and reads zero above them. Its fields drive outputs: tx_trig_sel_o = bits 1:0, rx_trig_sel_o = bits 4:2, brk_o = bit 8, smp_ofs_o = bits 13:9.
- R3: The rate word at 0x10 stores bits 7:0 and reads zero above them. rate_o changes only on a write to 0x10.
- R4: A read of 0x04 returns the transmit occupancy in bits 15:8 and the receive occupancy in bits 7:0.
- R5: Status bits 3 (framing error), 4 (break) and 5 (overrun) set on the clock edge that samples their pulse. Each holds until a write to status (0x08) has a one in that bit position. Zero bits in a status write have no effect.
- R6: An event arriving on the same edge as a clearing write to its bit leaves the bit set.
- R7: Status bits 1 and 2 show rx_trig_i and rx_tmo_i as sampled at the previous edge. Status writes do not change them.
- R8: Status bit 0 (transmit request) sets when the transmit occupancy moves from above the threshold to at or below it. The threshold comes from tx_trig_sel: 0→0, 1→4, 2→8, 3→16 entries. The bit stays set until a one is written to status bit 0. A level already at or below the threshold does not set it again.
- R9: Writing a one to status bit 6 sets status bit 0. Bit 6 always reads 0.
- R10: irq_o is the OR of three gated terms: bit 0 gated by control bit 5, bits 1 and 2 gated by control bit 6, and bits 5:3 gated by control bit 7.
- R11: Reads of addresses other than 0x04, 0x08, 0x0C and 0x10 return 0. Writes to those other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tx_level_i | input | LVL_W | Transmit FIFO occupancy |
| rx_level_i | input | LVL_W | Receive FIFO occupancy |
| rx_trig_i | input | 1 | Receive trigger level reached |
| rx_tmo_i | input | 1 | Receive idle timeout |
| fe_pulse_i | input | 1 | Framing error event |
| brk_pulse_i | input | 1 | Break received event |
| ovr_pulse_i | input | 1 | Receive overrun event |
| irq_o | output | 1 | Combined interrupt request |
| brk_o | output | 1 | Force break on transmit line |
| tx_trig_sel_o | output | 2 | Transmit trigger select |
| rx_trig_sel_o | output | 3 | Receive trigger select |
| smp_ofs_o | output | 5 | Receiver sampling offset |
| rate_o | output | RATE_W | Baud divider value |

## Verification
The properties take for granted that every event and level input is synchronous to clk and stable around the rising edge. They also take for granted that the bus does not write while it expects a read to reflect that write in the same cycle. The bench changes all inputs, including the write strobe, only just after a falling edge. It drops the write strobe and the event pulses before it reads back. Random occupancy stays between 0 and 20, so every threshold crossing is reached in both directions.

// File: rtl/uic_pkg.sv
package uic_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned LVL_FLD = 8;

  localparam logic [ADDR_W-1:0] OFS_LEVEL = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_RATE  = 5'h10;

  localparam int unsigned STAT_W   = 6;
  localparam int unsigned ST_TXREQ = 0;
  localparam int unsigned ST_RXTRG = 1;
  localparam int unsigned ST_RXTMO = 2;
  localparam int unsigned ST_ERR0  = 3;
  localparam int unsigned N_ERR    = 3;
  localparam int unsigned ST_FORCE = 6;

  typedef struct packed {
    logic [4:0] smp_ofs;
    logic       brk;
    logic       err_en;
    logic       rx_en;
    logic       tx_en;
    logic [2:0] rx_sel;
    logic [1:0] tx_sel;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/uic_ctrl_regs.sv
module uic_ctrl_regs
  import uic_pkg::*;
#(
  parameter int unsigned         RATE_W   = 8,
  parameter logic [RATE_W-1:0]   RATE_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              rate_we,
  input  logic [CTRL_W-1:0] ctrl_wd,
  input  logic [RATE_W-1:0] rate_wd,
  output ctrl_t             ctrl_q,
  output logic [RATE_W-1:0] rate_q
);
  ctrl_t             ctrl_d;
  logic [RATE_W-1:0] rate_d;

  always_comb begin
    ctrl_d = ctrl_q;
    rate_d = rate_q;
    if (ctrl_we) ctrl_d = ctrl_t'(ctrl_wd);
    if (rate_we) rate_d = rate_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rate_q <= RATE_RST;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (rate_we) rate_q <= rate_d;
    end
  end
endmodule

// File: rtl/uic_status.sv
module uic_status
  import uic_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              force_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [1:0]        tx_sel_i,
  input  logic              rx_trig_i,
  input  logic              rx_tmo_i,
  input  logic [N_ERR-1:0]  err_evt_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [LVL_W-1:0]  thr;
  logic              below_d, below_q;
  logic [STAT_W-1:0] stat_d, stat_q;

  always_comb begin
    if (tx_sel_i == 2'd0) thr = '0;
    else                  thr = LVL_W'(1) << ({1'b0, tx_sel_i} + 3'd1);
    below_d = (tx_level_i <= thr);
  end

  always_comb begin
    stat_d[ST_TXREQ] = (below_d && !below_q) || force_i ||
                       (stat_q[ST_TXREQ] && !clr_i[ST_TXREQ]);
    stat_d[ST_RXTRG] = rx_trig_i;
    stat_d[ST_RXTMO] = rx_tmo_i;
  end

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    always_comb begin
      stat_d[ST_ERR0+g] = err_evt_i[g] ||
                          (stat_q[ST_ERR0+g] && !clr_i[ST_ERR0+g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      below_q <= 1'b1;
    end else begin
      stat_q  <= stat_d;
      below_q <= below_d;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/uic_irq_gate.sv
module uic_irq_gate
  import uic_pkg::*;
(
  input  logic [STAT_W-1:0] stat_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              err_en_i,
  output logic              irq_o
);
  logic tx_term, rx_term, err_term;

  always_comb begin
    tx_term  = stat_i[ST_TXREQ] && tx_en_i;
    rx_term  = (stat_i[ST_RXTRG] || stat_i[ST_RXTMO]) && rx_en_i;
    err_term = (|stat_i[ST_ERR0 +: N_ERR]) && err_en_i;
    irq_o    = tx_term || rx_term || err_term;
  end
endmodule

// File: rtl/uart_irq_ctrl_regs.sv
module uart_irq_ctrl_regs
  import uic_pkg::*;
#(
  parameter int unsigned       LVL_W    = 8,
  parameter int unsigned       RATE_W   = 8,
  parameter logic [RATE_W-1:0] RATE_RST = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              rx_trig_i,
  input  logic              rx_tmo_i,
  input  logic              fe_pulse_i,
  input  logic              brk_pulse_i,
  input  logic              ovr_pulse_i,
  output logic              irq_o,
  output logic              brk_o,
  output logic [1:0]        tx_trig_sel_o,
  output logic [2:0]        rx_trig_sel_o,
  output logic [4:0]        smp_ofs_o,
  output logic [RATE_W-1:0] rate_o
);
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic              wr_stat, wr_ctrl, wr_rate;
  logic [STAT_W-1:0] clr_vec;
  logic              set_force;
  ctrl_t             ctrl_q;
  logic [STAT_W-1:0] stat_q;
  logic              en_tx, en_rx, en_err;
  logic              unused_wdata;

  always_comb begin
    wr_stat   = bus_wr && (bus_addr == OFS_STAT);
    wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
    wr_rate   = bus_wr && (bus_addr == OFS_RATE);
    clr_vec   = wr_stat ? bus_wdata[STAT_W-1:0] : '0;
    set_force = wr_stat && bus_wdata[ST_FORCE];
  end

  assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_W];

  uic_ctrl_regs #(
    .RATE_W   (RATE_W),
    .RATE_RST (RATE_RST)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ctrl_we (wr_ctrl),
    .rate_we (wr_rate),
    .ctrl_wd (bus_wdata[CTRL_W-1:0]),
    .rate_wd (bus_wdata[RATE_W-1:0]),
    .ctrl_q  (ctrl_q),
    .rate_q  (rate_o)
  );

  uic_status #(
    .LVL_W (LVL_W)
  ) u_stat (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (clr_vec),
    .force_i    (set_force),
    .tx_level_i (tx_level_i),
    .tx_sel_i   (ctrl_q.tx_sel),
    .rx_trig_i  (rx_trig_i),
    .rx_tmo_i   (rx_tmo_i),
    .err_evt_i  ({ovr_pulse_i, brk_pulse_i, fe_pulse_i}),
    .stat_o     (stat_q)
  );

  assign en_tx  = ctrl_q.tx_en;
  assign en_rx  = ctrl_q.rx_en;
  assign en_err = ctrl_q.err_en;

  uic_irq_gate u_irq (
    .stat_i   (stat_q),
    .tx_en_i  (en_tx),
    .rx_en_i  (en_rx),
    .err_en_i (en_err),
    .irq_o    (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_LEVEL: begin
        bus_rdata[LVL_W-1:0]         = rx_level_i;
        bus_rdata[LVL_FLD +: LVL_W]  = tx_level_i;
      end
      OFS_STAT: bus_rdata[STAT_W-1:0] = stat_q;
      OFS_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
      OFS_RATE: bus_rdata[RATE_W-1:0] = rate_o;
      default:  bus_rdata = '0;
    endcase
  end

  assign brk_o         = ctrl_q.brk;
  assign tx_trig_sel_o = ctrl_q.tx_sel;
  assign rx_trig_sel_o = ctrl_q.rx_sel;
  assign smp_ofs_o     = ctrl_q.smp_ofs;
endmodule

// File: rtl/uic_checker.sv
module uic_checker #(
  parameter int unsigned RATE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              rx_trig_i,
  input logic              fe_pulse_i,
  input logic [5:0]        stat_q,
  input logic              en_tx,
  input logic              en_rx,
  input logic              en_err,
  input logic              irq_o,
  input logic [RATE_W-1:0] rate_o
);
  logic wr_st;
  assign wr_st = bus_wr && (bus_addr == 5'h08);

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[3] && !(wr_st && bus_wdata[3])) |=> stat_q[3]); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fe_pulse_i |=> stat_q[3]); // R6
  AST_RX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (stat_q[1] == $past(rx_trig_i))); // R7
  AST_TXREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] && !(wr_st && bus_wdata[0])) |=> stat_q[0]); // R8
  AST_FORCE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && bus_wdata[6]) |=> stat_q[0]); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_tx && !en_rx && !en_err) |-> !irq_o); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == 6'd0) |-> !irq_o); // R10
  AST_RATE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 5'h10) |=> $stable(rate_o)); // R3
endmodule

bind uart_irq_ctrl_regs uic_checker #(.RATE_W(RATE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .rx_trig_i  (rx_trig_i),
  .fe_pulse_i (fe_pulse_i),
  .stat_q     (stat_q),
  .en_tx      (en_tx),
  .en_rx      (en_rx),
  .en_err     (en_err),
  .irq_o      (irq_o),
  .rate_o     (rate_o)
);

// File: tb/uart_irq_ctrl_regs_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_lvl, rx_lvl;
  logic        rx_trig, rx_tmo, fe, brk, ovr;
  logic        irq, brk_o;
  logic [1:0]  tx_sel_o;
  logic [2:0]  rx_sel_o;
  logic [4:0]  ofs_o;
  logic [7:0]  rate_o;

  int checks = 0;
  int fails  = 0;

  logic [5:0]  m_stat;
  logic [13:0] m_ctrl;
  logic [7:0]  m_rate;
  logic        m_below;

  always #2.5 clk = ~clk;

  uart_irq_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_level_i(tx_lvl),
    .rx_level_i(rx_lvl), .rx_trig_i(rx_trig), .rx_tmo_i(rx_tmo),
    .fe_pulse_i(fe), .brk_pulse_i(brk), .ovr_pulse_i(ovr), .irq_o(irq),
    .brk_o(brk_o), .tx_trig_sel_o(tx_sel_o), .rx_trig_sel_o(rx_sel_o),
    .smp_ofs_o(ofs_o), .rate_o(rate_o)
  );

  function automatic logic [7:0] thr_of(input logic [1:0] sel);
    case (sel)
      2'd0: return 8'd0;
      2'd1: return 8'd4;
      2'd2: return 8'd8;
      default: return 8'd16;
    endcase
  endfunction

  function automatic logic exp_irq(input logic [5:0] s, input logic [13:0] c);
    return (s[0] & c[5]) | ((s[1] | s[2]) & c[6]) | ((|s[5:3]) & c[7]);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  task automatic tick(input logic wr, input logic [4:0] a, input logic [31:0] d, input string tag);
    logic [31:0] clr;
    logic        below;
    logic [5:0]  n;
    logic [31:0] v;
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    clr   = (wr && a == 5'h08) ? d : 32'd0;
    below = (tx_lvl <= thr_of(m_ctrl[1:0]));
    n[0] = (below && !m_below) | clr[6] | (m_stat[0] & ~clr[0]);
    n[1] = rx_trig;
    n[2] = rx_tmo;
    n[3] = fe  | (m_stat[3] & ~clr[3]);
    n[4] = brk | (m_stat[4] & ~clr[4]);
    n[5] = ovr | (m_stat[5] & ~clr[5]);
    m_below = below;
    m_stat  = n;
    if (wr && a == 5'h0C) m_ctrl = d[13:0];
    if (wr && a == 5'h10) m_rate = d[7:0];
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; fe = 1'b0; brk = 1'b0; ovr = 1'b0;
    rd(5'h08, v); check(tag, v, {26'd0, m_stat});
    check("R10 irq", {31'd0, irq}, {31'd0, exp_irq(m_stat, m_ctrl)});
    rd(5'h0C, v); check("R2 ctrl", v, {18'd0, m_ctrl});
    rd(5'h10, v); check("R3 rate", v, {24'd0, m_rate});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'h5EED_0A17);
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    tx_lvl = 8'd40; rx_lvl = 8'd0; rx_trig = 0; rx_tmo = 0; fe = 0; brk = 0; ovr = 0;
    m_stat = '0; m_ctrl = '0; m_rate = 8'hFF; m_below = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(5'h08, v); check("R1 status", v, 32'd0);
    rd(5'h0C, v); check("R1 ctrl", v, 32'd0);
    rd(5'h10, v); check("R1 rate", v, 32'h0000_00FF);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 brk", {31'd0, brk_o}, 32'd0);

    // R2 control fields
    tick(1, 5'h0C, 32'hFFFF_FFFF, "R2");
    rd(5'h0C, v); check("R2 mask", v, 32'h0000_3FFF);
    check("R2 brk", {31'd0, brk_o}, 32'd1);
    check("R2 txsel", {30'd0, tx_sel_o}, 32'd3);
    check("R2 rxsel", {29'd0, rx_sel_o}, 32'd7);
    check("R2 ofs", {27'd0, ofs_o}, 32'd31);
    tick(1, 5'h0C, 32'h0000_2812, "R2");
    check("R2 ofs20", {27'd0, ofs_o}, 32'd20);
    check("R2 txsel2", {30'd0, tx_sel_o}, 32'd2);
    check("R2 rxsel4", {29'd0, rx_sel_o}, 32'd4);
    check("R2 nobrk", {31'd0, brk_o}, 32'd0);

    // R3 rate
    tick(1, 5'h10, 32'h1234_56A5, "R3");
    rd(5'h10, v); check("R3 read", v, 32'h0000_00A5);
    check("R3 out", {24'd0, rate_o}, 32'h0000_00A5);

    // R4 level word
    tx_lvl = 8'h2B; rx_lvl = 8'h11;
    rd(5'h04, v); check("R4 level", v, 32'h0000_2B11);

    // R11 unmapped addresses
    tick(1, 5'h00, 32'hFFFF_FFFF, "R11");
    tick(1, 5'h14, 32'hFFFF_FFFF, "R11");
    rd(5'h00, v); check("R11 rd00", v, 32'd0);
    rd(5'h14, v); check("R11 rd14", v, 32'd0);
    rd(5'h0C, v); check("R11 ctrl kept", v, 32'h0000_2812);

    // R5 latch and write-one-to-clear
    fe = 1'b1; tick(0, 5'h08, 0, "R5");
    rd(5'h08, v); check("R5 set", v, 32'h08);
    tick(0, 5'h08, 0, "R5");
    tick(1, 5'h08, 32'h0, "R5");
    rd(5'h08, v); check("R5 zero write", v, 32'h08);
    tick(1, 5'h08, 32'h8, "R5");
    rd(5'h08, v); check("R5 cleared", v, 32'h00);

    // R6 set beats clear
    ovr = 1'b1; tick(0, 5'h08, 0, "R6");
    ovr = 1'b1; tick(1, 5'h08, 32'h20, "R6");
    rd(5'h08, v); check("R6 kept", v, 32'h20);
    tick(1, 5'h08, 32'h20, "R6");

    // R7 receive level bits
    rx_trig = 1; rx_tmo = 1; tick(0, 5'h08, 0, "R7");
    tick(1, 5'h08, 32'h6, "R7");
    rd(5'h08, v); check("R7 ignore clear", v, 32'h06);
    rx_trig = 0; rx_tmo = 0; tick(0, 5'h08, 0, "R7");
    rd(5'h08, v); check("R7 follow", v, 32'h00);

    // R8 transmit threshold crossing
    tick(1, 5'h0C, 32'h0000_2801, "R8");
    tx_lvl = 8'd5; tick(0, 5'h08, 0, "R8");
    rd(5'h08, v); check("R8 above", v, 32'h00);
    tx_lvl = 8'd4; tick(0, 5'h08, 0, "R8");
    rd(5'h08, v); check("R8 at thr", v, 32'h01);
    tx_lvl = 8'd0; tick(0, 5'h08, 0, "R8");
    tick(1, 5'h08, 32'h1, "R8");
    tick(0, 5'h08, 0, "R8");
    rd(5'h08, v); check("R8 no re-set", v, 32'h00);
    tick(1, 5'h0C, 32'h0000_2800, "R8");
    tx_lvl = 8'd1; tick(0, 5'h08, 0, "R8");
    tx_lvl = 8'd0; tick(0, 5'h08, 0, "R8");
    rd(5'h08, v); check("R8 empty sel", v, 32'h01);
    tick(1, 5'h08, 32'h1, "R8");

    // R9 software set
    tick(1, 5'h08, 32'h40, "R9");
    rd(5'h08, v); check("R9 force", v, 32'h01);

    // R10 gating
    check("R10 tx off", {31'd0, irq}, 32'd0);
    tick(1, 5'h0C, 32'h0000_2820, "R10");
    check("R10 tx on", {31'd0, irq}, 32'd1);
    tick(1, 5'h08, 32'h1, "R10");
    brk = 1'b1; tick(0, 5'h08, 0, "R10");
    check("R10 err off", {31'd0, irq}, 32'd0);
    tick(1, 5'h0C, 32'h0000_2880, "R10");
    check("R10 err on", {31'd0, irq}, 32'd1);
    tick(1, 5'h0C, 32'h0000_2840, "R10");
    check("R10 rx idle", {31'd0, irq}, 32'd0);
    rx_trig = 1; tick(0, 5'h08, 0, "R10");
    check("R10 rx on", {31'd0, irq}, 32'd1);
    rx_trig = 0; tick(1, 5'h08, 32'h10, "R10");

    // Random mix against the model (R5 R6 R7 R8 R9 R10)
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      case ($urandom % 6)
        0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08;
        3: a = 5'h0C; 4: a = 5'h10; default: a = 5'h14;
      endcase
      tx_lvl  = 8'($urandom_range(0, 20));
      rx_lvl  = 8'($urandom);
      rx_trig = ($urandom % 3) == 0;
      rx_tmo  = ($urandom % 5) == 0;
      fe      = ($urandom % 9) == 0;
      brk     = ($urandom % 11) == 0;
      ovr     = ($urandom % 13) == 0;
      tick(($urandom % 4) == 0, a, $urandom, "R5R8 random");
    end

    finish_run();
  end
endmodule